// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in packed BCD with a 12-hour hour field and a PM flag. Its time base is an external mains-rate tick. A small prescaler divides the tick down so that the tenths-of-a-second field advances once every five ticks when 60 Hz operation is selected, or once every six ticks otherwise. The tenths, seconds, minutes and hours fields form a carry chain. The hours field counts 1 to 11 and then returns to 00, inverting the PM flag as it does so.

Software reaches four byte fields through a two-bit field select, with separate write and read strobes. A routing input sends writes either to the live time or to a matching set of alarm fields. Reading the hours field freezes the readable copy of the time, so that a multi-byte read stays coherent. Reading the tenths field releases it. The count itself never stops. Each time the tenths advance, the new time is compared with the alarm, and a full match produces a one-cycle alarm pulse for an interrupt controller outside this block.

Top module: `tod_clock`

## Requirements
- R1: After reset all time fields read 0x00, the readable copy is not frozen, alarm_o is low, and the prescaler is zero, so the first tick advances the tenths field.
- R2: With sel60_i high, after any advance the prescaler reloads to 4, so the tenths field advances again on the 5th following tick.
- R3: With sel60_i low the prescaler reloads to 5, so the tenths field advances again on the 6th following tick.
- R4: The tenths field (field 0) counts 0 to 9. Any advance from a value of 9 or more yields 0 and carries into the seconds field.
- R5: The seconds field (field 1) and the minutes field (field 2) are packed BCD from 00 to 59. A low digit past 9 carries into the high digit, and a value past 59 becomes 00 and carries into the next field.
- R6: The hours field (field 3) holds the PM flag in bit 7 and BCD hours in bits 4:0, and bits 6:5 read zero. An increment whose result is above 0x11 clears the hours and inverts the PM flag (0x11 becomes 0x80, and 0x91 becomes 0x00).
- R7: Time writes are masked with 0x0F for tenths, 0x7F for seconds and minutes, and 0x9F for hours.
- R8: While alarm_sel_i is high, a write goes to the alarm field and leaves the time unchanged. While it is low, a write goes to the time.
- R9: A read of field 3 freezes the value returned by all later reads, including later writes to the time. A read of field 0 returns the frozen value and then releases the freeze. Counting continues while the copy is frozen, so no time is lost.
- R10: alarm_o pulses high for exactly one cycle after a tick that advances the tenths field to a time equal to all four alarm fields. An equal time without an advance produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at the mains rate |
| sel60_i | input | 1 | 1 = 60 Hz tick (divide by 5), 0 = 50 Hz tick (divide by 6) |
| alarm_sel_i | input | 1 | 1 = writes go to the alarm fields |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (drives the freeze and release side effects) |
| addr_i | input | 2 | Field select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected time field (frozen copy while frozen) |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The hardest situation to reach is the freeze window. The bench must advance the time while the readable copy is frozen, and then show both the stale copy and the live count. It reads hours, ticks and writes while frozen, reads tenths once to see the frozen value, and reads tenths again to see the advanced value. The hour wrap with PM inversion needs a full carry from tenths through minutes. The bench loads 9, 59 and 59 ahead of each hour step so that one tick walks the whole chain. That step also lands on the all-zero alarm and checks the pulse.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_FLD = 4;
  localparam int FLD_W   = 8;

  typedef logic [NUM_FLD-1:0][FLD_W-1:0] tod_t;

  typedef enum logic [1:0] {
    FLD_TS = 2'd0,
    FLD_SC = 2'd1,
    FLD_MN = 2'd2,
    FLD_HR = 2'd3
  } fld_e;

  function automatic logic [FLD_W-1:0] fld_mask(input logic [1:0] f);
    case (f)
      FLD_TS:  return 8'h0F;
      FLD_HR:  return 8'h9F;
      default: return 8'h7F;
    endcase
  endfunction

  // {carry, value}
  function automatic logic [FLD_W:0] bcd60_inc(input logic [FLD_W-1:0] v);
    logic [4:0] lo;
    logic [3:0] hi;
    lo = {1'b0, v[3:0]} + 5'd1;
    hi = v[7:4];
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 4'd1;
    end
    if (hi > 4'd5) return {1'b1, 8'h00};
    return {1'b0, hi, lo[3:0]};
  endfunction

  function automatic logic [FLD_W-1:0] hr_inc(input logic [FLD_W-1:0] v);
    logic [4:0] lo;
    logic [1:0] hi;
    logic [5:0] r;
    lo = {1'b0, v[3:0]} + 5'd1;
    hi = {1'b0, v[4]};
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 2'd1;
    end
    r = {hi, lo[3:0]};
    if (r > 6'h11) return {~v[7], 7'h00};
    return {v[7], 2'b00, r[4:0]};
  endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int RELOAD_50 = 5,
  parameter int RELOAD_60 = 4,
  localparam int DIV_W = $clog2(((RELOAD_50 > RELOAD_60) ? RELOAD_50 : RELOAD_60) + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sel60_i,
  output logic adv_o
);
  logic [DIV_W-1:0] div_q;

  assign adv_o = tick_i && (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (tick_i) begin
      if (div_q == '0) div_q <= sel60_i ? DIV_W'(RELOAD_60) : DIV_W'(RELOAD_50);
      else             div_q <= div_q - 1'b1;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output tod_t       time_o,
  output tod_t       next_o
);
  tod_t time_q, time_d;
  logic [4:0] ts_inc;
  logic [8:0] sc_r, mn_r;
  logic c_ts;

  always_comb begin
    ts_inc = {1'b0, time_q[FLD_TS][3:0]} + 5'd1;
    c_ts   = ts_inc > 5'd9;
    sc_r   = bcd60_inc(time_q[FLD_SC]);
    mn_r   = bcd60_inc(time_q[FLD_MN]);
    next_o = time_q;
    next_o[FLD_TS] = c_ts ? 8'h00 : {3'b000, ts_inc};
    if (c_ts) begin
      next_o[FLD_SC] = sc_r[7:0];
      if (sc_r[8]) begin
        next_o[FLD_MN] = mn_r[7:0];
        if (mn_r[8]) next_o[FLD_HR] = hr_inc(time_q[FLD_HR]);
      end
    end
  end

  always_comb begin
    time_d = adv_i ? next_o : time_q;
    if (wr_en_i) time_d[addr_i] = wdata_i & fld_mask(addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_d;
  end

  assign time_o = time_q;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       adv_i,
  input  tod_t       cand_i,
  output logic       alarm_o
);
  tod_t alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q   <= '0;
      alarm_o <= 1'b0;
    end else begin
      if (wr_en_i) alm_q[addr_i] <= wdata_i & fld_mask(addr_i);
      alarm_o <= adv_i && (cand_i == alm_q);
    end
  end
endmodule

// File: rtl/tod_view.sv
module tod_view
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  tod_t       live_i,
  output logic [7:0] rdata_o,
  output logic       halt_o
);
  tod_t snap_q;
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      snap_q <= '0;
    end else if (rd_en_i) begin
      if (addr_i == FLD_HR && !halt_q) begin
        halt_q <= 1'b1;
        snap_q <= live_i;
      end else if (addr_i == FLD_TS) begin
        halt_q <= 1'b0;
      end
    end
  end

  assign rdata_o = halt_q ? snap_q[addr_i] : live_i[addr_i];
  assign halt_o  = halt_q;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int RELOAD_50 = 5,
  parameter int RELOAD_60 = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sel60_i,
  input  logic       alarm_sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       alarm_o
);
  logic adv_w, halt_w;
  tod_t live_w, next_w;

  tod_prescaler #(.RELOAD_50(RELOAD_50), .RELOAD_60(RELOAD_60)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel60_i(sel60_i), .adv_o(adv_w)
  );

  tod_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_w),
    .wr_en_i(wr_en_i && !alarm_sel_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .time_o(live_w), .next_o(next_w)
  );

  tod_alarm u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i && alarm_sel_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .adv_i(adv_w), .cand_i(next_w), .alarm_o(alarm_o)
  );

  tod_view u_view (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .live_i(live_w), .rdata_o(rdata_o), .halt_o(halt_w)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       alarm_sel_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       alarm_o,
  input logic       adv,
  input logic       halt,
  input tod_t       live
);
  assert_alarm_after_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(tick_i));

  assert_alarm_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> !alarm_o);

  assert_adv_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> !adv);

  assert_tenths_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !(wr_en_i && !alarm_sel_i)) |=> (live[0] <= 8'd9));

  assert_hr_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live[3][6:5] == 2'b00);

  assert_field_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live[0][7:4] == 4'h0) && !live[1][7] && !live[2][7]);

  assert_halt_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd3) |=> halt);

  assert_halt_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0) |=> !halt);

  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && $past(halt) && $stable(addr_i)) |-> $stable(rdata_o));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .alarm_sel_i(alarm_sel_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .alarm_o(alarm_o), .adv(adv_w), .halt(halt_w), .live(live_w)
);

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       sel60_i = 1'b1;
  logic       alarm_sel_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       alarm_o;

  int   checks = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       alm_exp = 1'b0;
  string      alm_tag = "";
  logic [7:0] e;
  string      t;

  always #2.5 clk_i = ~clk_i;

  tod_clock dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel60_i(sel60_i),
    .alarm_sel_i(alarm_sel_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_o(alarm_o)
  );

  // Monitor: pops expectations as reads and alarm windows occur
  always @(negedge clk_i) begin
    if (rst_ni && rd_en_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty rdata=%02h exp=none", rdata_o);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          bad++;
          $display("FAIL %s rdata=%02h exp=%02h", t, rdata_o, e);
        end
      end
    end
    if (rst_ni && alm_tag != "") begin
      checks++;
      if (alarm_o !== alm_exp) begin
        bad++;
        $display("FAIL %s alarm_o=%0b exp=%0b", alm_tag, alarm_o, alm_exp);
      end
    end else if (rst_ni && alarm_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 unexpected alarm_o=%0b exp=0", alarm_o);
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
    alm_tag = "";
    alm_exp = 1'b0;
  endtask

  task automatic do_reset();
    cyc();
    rst_ni = 1'b0;
    tick_i = 0; wr_en_i = 0; rd_en_i = 0; alarm_sel_i = 0; sel60_i = 1;
    cyc();
    cyc();
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic alm);
    cyc();
    alarm_sel_i = alm; wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    wr_en_i = 1'b0; alarm_sel_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] ex, input string tag);
    cyc();
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    cyc();
    rd_en_i = 1'b0;
  endtask

  task automatic tick(input logic ex, input string tag);
    cyc();
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
    alm_exp = ex;
    alm_tag = tag;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, "");
  endtask

  task automatic set_time(input logic [7:0] ts, sc, mn, hr);
    wr(2'd0, ts, 1'b0);
    wr(2'd1, sc, 1'b0);
    wr(2'd2, mn, 1'b0);
    wr(2'd3, hr, 1'b0);
  endtask

  // Reads all fields: hours read freezes, final tenths read releases
  task automatic rd_all(input logic [7:0] ts, sc, mn, hr, input string tag);
    rd(2'd1, sc, tag);
    rd(2'd2, mn, tag);
    rd(2'd3, hr, tag);
    rd(2'd0, ts, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    rd(2'd0, 8'h00, "R1 tenths");
    rd_all(8'h00, 8'h00, 8'h00, 8'h00, "R1 reset fields");
    tick(1'b0, "R1 no alarm on first tick");
    rd(2'd0, 8'h01, "R1 first tick advances");

    // R2: 60 Hz divide by 5
    ticks(4);
    rd(2'd0, 8'h01, "R2 no advance after 4");
    ticks(1);
    rd(2'd0, 8'h02, "R2 advance on 5th");

    // R3: 50 Hz divide by 6
    do_reset();
    sel60_i = 1'b0;
    ticks(1);
    ticks(5);
    rd(2'd0, 8'h01, "R3 no advance after 5");
    ticks(1);
    rd(2'd0, 8'h02, "R3 advance on 6th");

    // R4/R5: full carry chain
    do_reset();
    set_time(8'h09, 8'h59, 8'h59, 8'h05);
    ticks(1);
    rd_all(8'h00, 8'h00, 8'h00, 8'h06, "R5 carry to hours");
    do_reset();
    set_time(8'h09, 8'h09, 8'h00, 8'h00);
    ticks(1);
    rd_all(8'h00, 8'h10, 8'h00, 8'h00, "R5 low digit carry");

    // R7 masks, R4 out-of-range tenths
    do_reset();
    wr(2'd0, 8'hFF, 1'b0);
    wr(2'd1, 8'hFF, 1'b0);
    wr(2'd2, 8'hFF, 1'b0);
    wr(2'd3, 8'hFF, 1'b0);
    rd_all(8'h0F, 8'h7F, 8'h7F, 8'h9F, "R7 masks");
    set_time(8'h0F, 8'h00, 8'h00, 8'h01);
    ticks(1);
    rd(2'd0, 8'h00, "R4 tenths 0F wraps");
    rd(2'd1, 8'h01, "R4 carry into seconds");

    // R6 hours
    do_reset();
    set_time(8'h09, 8'h59, 8'h59, 8'h09);
    ticks(1);
    rd(2'd3, 8'h10, "R6 09 to 10");
    rd(2'd0, 8'h00, "R6 release");
    do_reset();
    set_time(8'h09, 8'h59, 8'h59, 8'h11);
    ticks(1);
    rd(2'd3, 8'h80, "R6 11 to PM 00");
    rd(2'd0, 8'h00, "R6 release");
    do_reset();
    set_time(8'h09, 8'h59, 8'h59, 8'h91);
    tick(1'b1, "R10 match at all-zero alarm");
    rd(2'd3, 8'h00, "R6 PM 11 to 00");
    rd(2'd0, 8'h00, "R6 release");

    // R8 routing, R10 alarm
    do_reset();
    wr(2'd1, 8'h12, 1'b1);
    rd(2'd1, 8'h00, "R8 alarm write leaves time");
    wr(2'd1, 8'h00, 1'b1);
    wr(2'd0, 8'h02, 1'b1);
    rd(2'd0, 8'h00, "R8 tenths untouched");
    tick(1'b0, "R10 no match at 1");
    ticks(4);
    tick(1'b1, "R10 match at 2");
    cyc();
    alm_exp = 1'b0; alm_tag = "R10 single cycle";
    tick(1'b0, "R10 no advance no pulse");

    // R9 freeze
    do_reset();
    wr(2'd1, 8'h30, 1'b0);
    rd(2'd3, 8'h00, "R9 hours read freezes");
    ticks(1);
    wr(2'd3, 8'h05, 1'b0);
    rd(2'd3, 8'h00, "R9 hours frozen");
    rd(2'd1, 8'h30, "R9 seconds frozen");
    rd(2'd0, 8'h00, "R9 tenths frozen");
    rd(2'd0, 8'h01, "R9 no time lost");
    rd(2'd3, 8'h05, "R9 write applied");
    rd(2'd0, 8'h01, "R9 release");

    cyc();
    cyc();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule